// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. In each cycle it fetches a word from an instruction memory, decodes it, reads two operands from a 32-entry register file and computes a result in the ALU. It then either reads or writes the data memory, or does neither, and writes any result back before the next rising edge. It recognises seven instructions: register add, register subtract, OR with an immediate, load word, store word, branch when two registers are equal, and an unconditional jump. It has no pipeline, so there are no hazards to handle and every instruction sees the effects of the one before it.

The core drives a word index to the instruction memory and receives the instruction word back in the same cycle. Both memories are expected to answer reads combinationally. The data memory port carries a byte address, write data and a write enable, and returns read data combinationally. Writes to the registers and to the data memory take effect at the rising clock edge. Any instruction outside the supported set changes no register and no memory location, and the core then moves on to the next word.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the program counter is held at byte address 0. `imem_addr` always equals the program counter divided by 4.
- R2: After any instruction other than a taken branch or a jump, the program counter advances by 4 bytes.
- R3: Branch-if-equal (opcode 000100) compares rs with rt. When they are equal, the next program counter is PC+4 plus the sign-extended 16-bit immediate shifted left by two. When they differ, the next program counter is PC+4. A branch writes neither a register nor memory.
- R4: Jump (opcode 000010) loads the program counter with the top 4 bits of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R5: Instruction fields are opcode 31:26, rs 25:21, rt 20:16, rd 15:11 and function 5:0. With opcode 000000, function 100000 writes rs+rt to rd and function 100010 writes rs-rt to rd, both wrapping modulo 2^32.
- R6: OR-immediate (opcode 001101) writes rs OR the zero-extended immediate (bits 15:0) to rt.
- R7: Load word (opcode 100011) reads data memory at rs plus the sign-extended immediate and writes the returned word to rt.
- R8: Store word (opcode 101011) drives rt onto `dmem_wdata` and rs plus the sign-extended immediate onto `dmem_addr`, with `dmem_we` high. `dmem_we` is high for no other instruction.
- R9: Register 0 always reads as zero. A write aimed at register 0 is discarded.
- R10: An unsupported opcode, or opcode 000000 with a function other than 100000 or 100010, changes no register and no memory location, and the program counter advances by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state update happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| imem_addr | output | IMEM_AW (10) | Word index of the instruction being fetched |
| imem_data | input | XLEN (32) | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | XLEN (32) | Byte address for a load or store |
| dmem_wdata | output | XLEN (32) | Store data, taken from rt |
| dmem_we | output | 1 | Data memory write strobe, high only for a store |
| dmem_rdata | input | XLEN (32) | Word read combinationally at `dmem_addr` |

## Verification
Register contents never appear at the ports, so every register effect has to be made visible by a later store. The bench program follows each write, including the discarded write to register 0 and the skipped unsupported instructions, with a store of that register. The scoreboard then checks the exact address and data of every store, and it reports any store it was not expecting. The control-flow cases are a branch with unequal operands, a forward branch, a jump that skips stores which must never appear, and a backward branch with offset -1 that loops on itself. All of these are checked through the word index the core presents on every cycle.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_LW    = 6'b100011;
  localparam logic [5:0] OPC_SW    = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JMP   = 6'b000010;

  localparam logic [5:0] FN_ADD    = 6'b100000;
  localparam logic [5:0] FN_SUB    = 6'b100010;

  localparam int unsigned JADDR_W  = 26;
  localparam int unsigned IMM_W    = 16;

  typedef enum logic [2:0] {
    ALU_NONE = 3'b000,
    ALU_OR   = 3'b001,
    ALU_ADD  = 3'b010,
    ALU_SUB  = 3'b110
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;    // destination: 0 rt, 1 rd
    logic    src_imm;   // second operand: 0 register, 1 immediate
    logic    wb_mem;    // write-back: 0 ALU, 1 memory
    logic    reg_we;
    logic    mem_we;
    logic    branch;
    logic    jump;
    logic    ext_sign;  // 0 zero-extend, 1 sign-extend
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_NONE;
    unique case (opcode)
      OPC_RTYPE: begin
        if (funct == FN_ADD || funct == FN_SUB) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_we = 1'b1;
          ctrl.alu_op = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
        end
      end
      OPC_ORI: begin
        ctrl.src_imm = 1'b1;
        ctrl.reg_we  = 1'b1;
        ctrl.alu_op  = ALU_OR;
      end
      OPC_LW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.reg_we   = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      OPC_SW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.mem_we   = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.alu_op   = ALU_ADD;
      end
      OPC_BEQ: begin
        ctrl.branch   = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.alu_op   = ALU_SUB;
      end
      OPC_JMP: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [AW-1:0]   ra_idx,
  input  logic [AW-1:0]   rb_idx,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data
);

  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (wr_en && wr_idx != '0) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign ra_data = (ra_idx == '0) ? '0 : mem[ra_idx];
  assign rb_data = (rb_idx == '0) ? '0 : mem[rb_idx];

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  alu_op_e         op,
  output logic [XLEN-1:0] res,
  output logic            is_zero
);

  always_comb begin
    unique case (op)
      ALU_OR:  res = opa | opb;
      ALU_ADD: res = opa + opb;
      ALU_SUB: res = opa - opb;
      default: res = '0;
    endcase
  end

  assign is_zero = (res == '0);

endmodule

// File: rtl/sc_fetch.sv
module sc_fetch
  import sc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IMEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_branch,
  input  logic               take_jump,
  input  logic [XLEN-1:0]    br_offset,
  input  logic [JADDR_W-1:0] jaddr,
  output logic [IMEM_AW-1:0] fetch_idx
);

  logic [XLEN-1:0] pc;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] j_target;
  logic [XLEN-1:0] pc_next;

  assign pc_plus4  = pc + XLEN'(4);
  assign br_target = pc_plus4 + {br_offset[XLEN-3:0], 2'b00};
  assign j_target  = {pc_plus4[XLEN-1:JADDR_W+2], jaddr, 2'b00};

  always_comb begin
    if (take_jump)        pc_next = j_target;
    else if (take_branch) pc_next = br_target;
    else                  pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign fetch_idx = pc[IMEM_AW+1:2];

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!take_branch && !take_jump) |=> (pc == $past(pc) + XLEN'(4))); // R2

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    take_jump |=> (pc[JADDR_W+1:2] == $past(jaddr) && pc[1:0] == 2'b00)); // R4

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (take_branch && !take_jump) |=>
      (pc == $past(pc) + XLEN'(4) + ($past(br_offset) << 2))); // R3

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NREG    = 32,
  parameter int unsigned IMEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [XLEN-1:0]    imem_data,
  output logic [XLEN-1:0]    dmem_addr,
  output logic [XLEN-1:0]    dmem_wdata,
  output logic               dmem_we,
  input  logic [XLEN-1:0]    dmem_rdata
);

  localparam int unsigned RAW = $clog2(NREG);

  logic [5:0]         opcode;
  logic [5:0]         funct;
  logic [RAW-1:0]     rs_idx;
  logic [RAW-1:0]     rt_idx;
  logic [RAW-1:0]     rd_idx;
  logic [IMM_W-1:0]   imm;
  logic [JADDR_W-1:0] jaddr;

  ctrl_t              ctrl;
  logic [XLEN-1:0]    rs_val;
  logic [XLEN-1:0]    rt_val;
  logic [XLEN-1:0]    imm_ext;
  logic [XLEN-1:0]    alu_b;
  logic [XLEN-1:0]    alu_y;
  logic               alu_zero;
  logic [XLEN-1:0]    wb_data;
  logic [RAW-1:0]     wb_idx;
  logic               take_branch;

  assign opcode = imem_data[31:26];
  assign rs_idx = imem_data[21 +: RAW];
  assign rt_idx = imem_data[16 +: RAW];
  assign rd_idx = imem_data[11 +: RAW];
  assign funct  = imem_data[5:0];
  assign imm    = imem_data[IMM_W-1:0];
  assign jaddr  = imem_data[JADDR_W-1:0];

  sc_decoder u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .ra_idx  (rs_idx),
    .rb_idx  (rt_idx),
    .ra_data (rs_val),
    .rb_data (rt_val),
    .wr_en   (ctrl.reg_we),
    .wr_idx  (wb_idx),
    .wr_data (wb_data)
  );

  assign imm_ext = ctrl.ext_sign ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm}
                                 : {{(XLEN-IMM_W){1'b0}}, imm};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  sc_alu #(.XLEN(XLEN)) u_alu (
    .opa     (rs_val),
    .opb     (alu_b),
    .op      (ctrl.alu_op),
    .res     (alu_y),
    .is_zero (alu_zero)
  );

  assign take_branch = ctrl.branch & alu_zero;

  sc_fetch #(.XLEN(XLEN), .IMEM_AW(IMEM_AW)) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .take_branch (take_branch),
    .take_jump   (ctrl.jump),
    .br_offset   (imm_ext),
    .jaddr       (jaddr),
    .fetch_idx   (imem_addr)
  );

  assign wb_idx     = ctrl.dst_rd ? rd_idx : rt_idx;
  assign wb_data    = ctrl.wb_mem ? dmem_rdata : alu_y;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.mem_we;

  AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (opcode == OPC_SW)); // R8

  AST_BEQ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_BEQ) |-> (!ctrl.reg_we && !dmem_we)); // R3

  AST_UNSUPPORTED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_RTYPE && opcode != OPC_ORI && opcode != OPC_LW &&
     opcode != OPC_SW && opcode != OPC_BEQ && opcode != OPC_JMP)
      |-> (!ctrl.reg_we && !dmem_we && !take_branch && !ctrl.jump)); // R10

  AST_RTYPE_DEST: assert property (@(posedge clk) disable iff (rst)
    (opcode == OPC_RTYPE && ctrl.reg_we) |-> (wb_idx == rd_idx)); // R5

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  imem_addr;
  logic [31:0] imem_data;
  logic [31:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic        dmem_we;
  logic [31:0] dmem_rdata;

  always #4 clk = ~clk;

  logic [31:0] rom [64];
  logic [31:0] ram [64];

  assign imem_data  = rom[imem_addr[5:0]];
  assign dmem_rdata = ram[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) ram[dmem_addr[7:2]] <= dmem_wdata;
  end

  sc_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit go       = 1'b0;
  bit done     = 1'b0;

  int          pc_q[$];
  string       pc_tag_q[$];
  logic [31:0] st_addr_q[$];
  logic [31:0] st_data_q[$];
  string       st_atag_q[$];
  string       st_dtag_q[$];

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic exp_pc(int idx, string tag);
    pc_q.push_back(idx);
    pc_tag_q.push_back(tag);
  endtask

  task automatic exp_store(logic [31:0] a, logic [31:0] d, string at, string dt);
    st_addr_q.push_back(a);
    st_data_q.push_back(d);
    st_atag_q.push_back(at);
    st_dtag_q.push_back(dt);
  endtask

  // Driver: program, expectations, reset
  initial begin
    for (int i = 0; i < 64; i++) begin
      rom[i] = 32'hFC00_0000;
      ram[i] = 32'h0;
    end
    rom[0]  = enc_i(6'b001101, 0, 1, 16'h00F0);   // ori r1 = 0xF0
    rom[1]  = enc_i(6'b001101, 0, 2, 16'h8001);   // ori r2 = 0x8001 (zero ext)
    rom[2]  = enc_r(1, 2, 3, 6'b100000);          // add r3
    rom[3]  = enc_r(1, 2, 4, 6'b100010);          // sub r4
    rom[4]  = enc_i(6'b101011, 0, 3, 16'd0);      // sw r3,0
    rom[5]  = enc_i(6'b101011, 0, 4, 16'd4);      // sw r4,4
    rom[6]  = enc_i(6'b101011, 1, 2, 16'hFFFC);   // sw r2,-4(r1)
    rom[7]  = enc_i(6'b100011, 0, 5, 16'd4);      // lw r5,4
    rom[8]  = enc_i(6'b101011, 0, 5, 16'd8);      // sw r5,8
    rom[9]  = enc_i(6'b001101, 0, 0, 16'h1234);   // ori r0 (discarded)
    rom[10] = enc_i(6'b101011, 0, 0, 16'd12);     // sw r0,12
    rom[11] = enc_i(6'b000100, 1, 2, 16'd5);      // beq not taken
    rom[12] = enc_i(6'b000100, 1, 1, 16'd2);      // beq taken -> word 15
    rom[13] = enc_i(6'b101011, 0, 1, 16'd16);     // skipped
    rom[14] = enc_i(6'b101011, 0, 1, 16'd16);     // skipped
    rom[15] = enc_i(6'b101011, 0, 1, 16'd20);     // sw r1,20
    rom[16] = enc_j(26'd20);                      // jump -> word 20
    rom[17] = enc_i(6'b101011, 0, 1, 16'd24);     // skipped
    rom[18] = enc_i(6'b101011, 0, 1, 16'd24);     // skipped
    rom[19] = enc_i(6'b101011, 0, 1, 16'd24);     // skipped
    rom[20] = enc_i(6'b111111, 0, 1, 16'h5555);   // unsupported opcode
    rom[21] = enc_r(2, 2, 1, 6'b100100);          // unsupported function
    rom[22] = enc_i(6'b101011, 0, 1, 16'd28);     // sw r1,28
    rom[23] = enc_i(6'b000100, 0, 0, 16'hFFFF);   // beq self loop

    exp_pc(0, "R1");
    for (int i = 1; i <= 12; i++) exp_pc(i, (i == 12) ? "R3" : "R2");
    exp_pc(15, "R3");
    exp_pc(16, "R2");
    exp_pc(20, "R4");
    exp_pc(21, "R10");
    exp_pc(22, "R10");
    exp_pc(23, "R2");
    for (int i = 0; i < 5; i++) exp_pc(23, "R3");

    exp_store(32'h0000_0000, 32'h0000_80F1, "R8", "R5");
    exp_store(32'h0000_0004, 32'hFFFF_80EF, "R8", "R5");
    exp_store(32'h0000_00EC, 32'h0000_8001, "R8", "R6");
    exp_store(32'h0000_0008, 32'hFFFF_80EF, "R8", "R7");
    exp_store(32'h0000_000C, 32'h0000_0000, "R8", "R9");
    exp_store(32'h0000_0014, 32'h0000_00F0, "R8", "R3");
    exp_store(32'h0000_001C, 32'h0000_00F0, "R8", "R10");

    repeat (3) @(negedge clk);
    chk("R1", "pc held in reset", 32'(imem_addr), 32'd0);
    chk("R8", "no store in reset", 32'(dmem_we), 32'd0);
    rst = 1'b0;
    go  = 1'b1;
  end

  // Monitor: pop and compare once per cycle
  initial begin
    int idx;
    string tag;
    wait (go);
    while (pc_q.size() > 0) begin
      idx = pc_q.pop_front();
      tag = pc_tag_q.pop_front();
      chk(tag, "fetch index", 32'(imem_addr), 32'(idx));
      if (dmem_we === 1'b1) begin
        if (st_addr_q.size() == 0) begin
          chk("R8", "unexpected store addr", dmem_addr, 32'hFFFF_FFFF);
        end else begin
          chk(st_atag_q.pop_front(), "store addr", dmem_addr, st_addr_q.pop_front());
          chk(st_dtag_q.pop_front(), "store data", dmem_wdata, st_data_q.pop_front());
        end
      end
      @(negedge clk);
    end
    chk("R8", "stores left over", 32'(st_addr_q.size()), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule